// File: doc/BRIEF.md
# Clock and Strobe Signalling Mode Controller

This block owns the electrical signalling mode of three memory-interface clocks: the command clock, the write clock and the read strobe. Each one runs either as a differential pair or as a single-ended line, and the read strobe may also be switched off entirely. When the read strobe is off, the read path must capture data with a strobe it generates itself. Software or a power manager presents a requested mode together with the current data rate. The block checks the request against the allowed signal combinations and the rate ceiling. It rejects illegal requests with a one-cycle error pulse and applies legal ones through a timed sequence.

Termination on the clock, strobe, command/address, data and mask lines may stay enabled only while all three signals are differential. The sequencer therefore turns termination off before leaving fully differential operation, and turns it back on only after returning to it. Every step is followed by a programmable settle interval. While a sequence runs, the block is busy and ignores new requests.

Top module: `sigmode_ctrl`

## Requirements
- R1: After reset all three signals are differential (all mode outputs 0), all six termination enables are 1, and `busy`, `req_err` and `int_strobe_en` are 0.
- R2: Mode bits use 0 for differential and 1 for single-ended, plus a separate strobe-off bit. Exactly four shapes are legal: all differential; command clock single-ended with the others differential; command clock, write clock and read strobe all single-ended; command clock and write clock single-ended with the read strobe off. Every other shape is illegal.
- R3: Any shape other than all-differential is legal only when `rate_mbps` is at most 1600 in the accept cycle. All-differential is legal at any rate.
- R4: An illegal request seen while idle makes `req_err` high for exactly the one cycle after the request edge. It leaves the mode and termination outputs unchanged.
- R5: When leaving all-differential operation, termination goes to 0 in the cycle after acceptance. The new mode appears S+1 cycles later, and `busy` falls S+1 cycles after that, where S = `settle_cyc`.
- R6: When returning to all-differential operation, the new mode appears in the cycle after acceptance. Termination returns to 1 S+1 cycles later, and `busy` falls S+1 cycles after that.
- R7: A change between two non-differential shapes applies the mode in the cycle after acceptance, leaves termination at 0, and drops `busy` S+1 cycles later.
- R8: All six termination enables always carry the same value. They are 0 whenever any signal is single-ended or the strobe is off.
- R9: `int_strobe_en` equals the applied strobe-off bit.
- R10: The applied polarity `strobe_pol`, shared by the write clock and the read strobe, takes the requested polarity when the write clock is single-ended and is 0 otherwise.
- R11: A request presented while `busy` is 1 is ignored: it raises no error and does not alter the result of the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Mode change request strobe |
| req_ck_se | input | 1 | Requested command clock mode (1 = single-ended) |
| req_wck_se | input | 1 | Requested write clock mode (1 = single-ended) |
| req_rdqs_se | input | 1 | Requested read strobe mode (1 = single-ended) |
| req_rdqs_off | input | 1 | Requested read strobe off |
| req_pol | input | 1 | Requested active polarity for write clock and read strobe |
| rate_mbps | input | 14 | Current data rate in Mbps |
| settle_cyc | input | 8 | Settle interval per sequencing step |
| busy | output | 1 | Sequence in progress |
| req_err | output | 1 | One-cycle pulse on rejected request |
| ck_se | output | 1 | Applied command clock mode |
| wck_se | output | 1 | Applied write clock mode |
| rdqs_se | output | 1 | Applied read strobe mode |
| rdqs_off | output | 1 | Applied read strobe off |
| strobe_pol | output | 1 | Applied shared polarity |
| term_en | output | 6 | Termination enables, bit 0..5: command clock, write clock, read strobe, command/address, data, mask |
| int_strobe_en | output | 1 | Read path must use its internal strobe |

## Verification
The request check and the end of a running sequence can fall in the same cycle. A request may arrive on the very edge where the last settle interval expires and `busy` falls. The bench provokes this by counting the cycles of a known sequence and presenting an illegal request exactly on that final edge. It then judges that no error pulse follows and the mode is the one just applied. Acceptance during the middle of a sequence is covered the same way with a legal request, which must also leave no trace.

// File: rtl/sigmode_pkg.sv
// Shared types for the signalling mode controller.
// Assumes one mode record per request; polarity is shared by write clock and read strobe.
package sigmode_pkg;
    localparam int TERM_N = 6;

    typedef struct packed {
        logic ck_se;
        logic wck_se;
        logic rdqs_se;
        logic rdqs_off;
        logic pol;
    } sig_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TOFF   = 2'd1,
        ST_SWITCH = 2'd2,
        ST_TON    = 2'd3
    } seq_state_t;
endpackage

// File: rtl/sigmode_legal.sv
// Combinational legality check of a requested signalling mode.
// Assumes the rate input is sampled by the caller in the same cycle as the request.
module sigmode_legal
    import sigmode_pkg::*;
#(
    parameter int RATE_W     = 14,
    parameter int RATE_LIMIT = 1600
) (
    input  sig_mode_t         req_mode,
    input  logic [RATE_W-1:0] rate_mbps,
    output logic              legal,
    output logic              full_diff
);
    localparam logic [RATE_W-1:0] LIMIT_V = RATE_W'(RATE_LIMIT);

    logic shape_ok;
    logic rate_ok;

    // Classify the request into one of the four permitted shapes.
    always_comb begin
        full_diff = !(req_mode.ck_se | req_mode.wck_se | req_mode.rdqs_se | req_mode.rdqs_off);
        shape_ok  = full_diff
                  | ( req_mode.ck_se & !req_mode.wck_se & !req_mode.rdqs_se & !req_mode.rdqs_off)
                  | ( req_mode.ck_se &  req_mode.wck_se &  req_mode.rdqs_se & !req_mode.rdqs_off)
                  | ( req_mode.ck_se &  req_mode.wck_se & !req_mode.rdqs_se &  req_mode.rdqs_off);
        rate_ok   = full_diff | (rate_mbps <= LIMIT_V);
        legal     = shape_ok & rate_ok;
    end
endmodule

// File: rtl/sigmode_timer.sv
// Settle-interval down counter.
// Assumes load and check never coincide in a way that needs the old count.
module sigmode_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    // Interval is over once the count reaches zero.
    always_comb expired = (cnt == '0);
endmodule

// File: rtl/sigmode_seq.sv
// Sequencer: accepts or rejects requests, orders termination against the mode switch.
// Assumes a timer that is reloaded through tmr_load and reports expiry.
module sigmode_seq
    import sigmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  sig_mode_t req_mode,
    input  logic      req_legal,
    input  logic      req_full_diff,
    input  logic      tmr_expired,
    output logic      tmr_load,
    output logic      busy,
    output logic      req_err,
    output sig_mode_t cur_mode,
    output logic      term_on
);
    seq_state_t state;
    sig_mode_t  pend_mode;
    sig_mode_t  masked;
    logic       returning;
    logic       cur_full_diff;
    logic       accept;

    // Derive acceptance and the polarity-masked mode.
    always_comb begin
        cur_full_diff = !(cur_mode.ck_se | cur_mode.wck_se | cur_mode.rdqs_se | cur_mode.rdqs_off);
        accept        = (state == ST_IDLE) && req_valid && req_legal;
        masked        = req_mode;
        masked.pol    = req_mode.wck_se & req_mode.pol;
    end

    // Timer reload at each sequencing step.
    always_comb begin
        tmr_load = accept
                 | ((state == ST_TOFF)   && tmr_expired)
                 | ((state == ST_SWITCH) && tmr_expired && returning);
    end

    // Main state machine and applied-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_mode  <= '0;
            pend_mode <= '0;
            term_on   <= 1'b1;
            returning <= 1'b0;
            req_err   <= 1'b0;
        end else begin
            req_err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid && !req_legal) begin
                        req_err <= 1'b1;
                    end else if (accept) begin
                        pend_mode <= masked;
                        if (cur_full_diff && !req_full_diff) begin
                            term_on <= 1'b0;
                            state   <= ST_TOFF;
                        end else begin
                            cur_mode  <= masked;
                            returning <= !cur_full_diff && req_full_diff;
                            state     <= ST_SWITCH;
                        end
                    end
                end
                ST_TOFF: begin
                    if (tmr_expired) begin
                        cur_mode  <= pend_mode;
                        returning <= 1'b0;
                        state     <= ST_SWITCH;
                    end
                end
                ST_SWITCH: begin
                    if (tmr_expired) begin
                        if (returning) begin
                            term_on <= 1'b1;
                            state   <= ST_TON;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_TON: begin
                    if (tmr_expired) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Busy whenever a sequence is running.
    always_comb busy = (state != ST_IDLE);
endmodule

// File: rtl/sigmode_ctrl.sv
// Top: signalling mode controller for command clock, write clock and read strobe.
// Assumes rate_mbps and settle_cyc are stable around a request.
module sigmode_ctrl
    import sigmode_pkg::*;
#(
    parameter int RATE_W     = 14,
    parameter int CNT_W      = 8,
    parameter int RATE_LIMIT = 1600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ck_se,
    input  logic              req_wck_se,
    input  logic              req_rdqs_se,
    input  logic              req_rdqs_off,
    input  logic              req_pol,
    input  logic [RATE_W-1:0] rate_mbps,
    input  logic [CNT_W-1:0]  settle_cyc,
    output logic              busy,
    output logic              req_err,
    output logic              ck_se,
    output logic              wck_se,
    output logic              rdqs_se,
    output logic              rdqs_off,
    output logic              strobe_pol,
    output logic [TERM_N-1:0] term_en,
    output logic              int_strobe_en
);
    sig_mode_t req_mode;
    sig_mode_t cur_mode;
    logic      legal;
    logic      full_diff;
    logic      tmr_load;
    logic      tmr_expired;
    logic      term_on;

    // Pack request pins into a mode record.
    always_comb req_mode = '{ck_se: req_ck_se, wck_se: req_wck_se, rdqs_se: req_rdqs_se,
                             rdqs_off: req_rdqs_off, pol: req_pol};

    sigmode_legal #(.RATE_W(RATE_W), .RATE_LIMIT(RATE_LIMIT)) u_legal (
        .req_mode  (req_mode),
        .rate_mbps (rate_mbps),
        .legal     (legal),
        .full_diff (full_diff)
    );

    sigmode_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (settle_cyc),
        .expired  (tmr_expired)
    );

    sigmode_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_mode      (req_mode),
        .req_legal     (legal),
        .req_full_diff (full_diff),
        .tmr_expired   (tmr_expired),
        .tmr_load      (tmr_load),
        .busy          (busy),
        .req_err       (req_err),
        .cur_mode      (cur_mode),
        .term_on       (term_on)
    );

    // Fan termination control out to every terminated line group.
    for (genvar g = 0; g < TERM_N; g++) begin : g_term
        assign term_en[g] = term_on;
    end

    // Drive applied-mode outputs.
    always_comb begin
        ck_se         = cur_mode.ck_se;
        wck_se        = cur_mode.wck_se;
        rdqs_se       = cur_mode.rdqs_se;
        rdqs_off      = cur_mode.rdqs_off;
        strobe_pol    = cur_mode.pol;
        int_strobe_en = cur_mode.rdqs_off;
    end
endmodule

// File: rtl/sigmode_ctrl_chk.sv
// Checker bound to the top: legality of applied modes, termination ordering, error pulse.
// Assumes observation through top-level ports only.
module sigmode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       req_err,
    input logic       ck_se,
    input logic       wck_se,
    input logic       rdqs_se,
    input logic       rdqs_off,
    input logic       strobe_pol,
    input logic [5:0] term_en,
    input logic       int_strobe_en
);
    logic [4:0] mode_bus;
    assign mode_bus = {ck_se, wck_se, rdqs_se, rdqs_off, strobe_pol};

    assert_wck_needs_ck_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wck_se || rdqs_se || rdqs_off) |-> ck_se);
    assert_rdqs_needs_wck_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdqs_se || rdqs_off) |-> wck_se);
    assert_wck_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wck_se |-> (rdqs_se ^ rdqs_off));
    assert_err_holds_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> ($stable(mode_bus) && !busy));
    assert_term_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_se || wck_se || rdqs_se || rdqs_off) |-> (term_en == 6'd0));
    assert_term_uniform_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (term_en == 6'd0) || (term_en == 6'h3F));
    assert_strobe_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_strobe_en |-> (ck_se && wck_se && !rdqs_se));
    assert_pol_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wck_se |-> !strobe_pol);
    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> $stable(mode_bus));
endmodule

bind sigmode_ctrl sigmode_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .req_err       (req_err),
    .ck_se         (ck_se),
    .wck_se        (wck_se),
    .rdqs_se       (rdqs_se),
    .rdqs_off      (rdqs_off),
    .strobe_pol    (strobe_pol),
    .term_en       (term_en),
    .int_strobe_en (int_strobe_en)
);

// File: tb/sigmode_ctrl_tb.sv
module sigmode_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        r_ck = 1'b0, r_wck = 1'b0, r_rse = 1'b0, r_off = 1'b0, r_pol = 1'b0;
    logic [13:0] rate = 14'd6400;
    logic [7:0]  settle = 8'd1;
    logic        busy, req_err, ck_se, wck_se, rdqs_se, rdqs_off, strobe_pol, int_strobe_en;
    logic [5:0]  term_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sigmode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_ck_se(r_ck), .req_wck_se(r_wck), .req_rdqs_se(r_rse),
        .req_rdqs_off(r_off), .req_pol(r_pol), .rate_mbps(rate), .settle_cyc(settle),
        .busy(busy), .req_err(req_err), .ck_se(ck_se), .wck_se(wck_se),
        .rdqs_se(rdqs_se), .rdqs_off(rdqs_off), .strobe_pol(strobe_pol),
        .term_en(term_en), .int_strobe_en(int_strobe_en)
    );

    // vector: {ck, wck, rdqs_se, rdqs_off, pol, rate[13:0], legal}
    localparam int NV = 17;
    localparam logic [19:0] VEC [NV] = '{
        {5'b10000, 14'd1600, 1'b1},
        {5'b11100, 14'd1600, 1'b1},
        {5'b11101, 14'd800,  1'b1},
        {5'b11010, 14'd1600, 1'b1},
        {5'b11011, 14'd400,  1'b1},
        {5'b00000, 14'd6400, 1'b1},
        {5'b01000, 14'd800,  1'b0},
        {5'b00100, 14'd800,  1'b0},
        {5'b11000, 14'd800,  1'b0},
        {5'b11110, 14'd800,  1'b0},
        {5'b10000, 14'd1601, 1'b0},
        {5'b00010, 14'd800,  1'b0},
        {5'b10100, 14'd800,  1'b0},
        {5'b10000, 14'd1600, 1'b1},
        {5'b10001, 14'd1200, 1'b1},
        {5'b11100, 14'd2000, 1'b0},
        {5'b00000, 14'd3200, 1'b1}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] cur_out();
        return {ck_se, wck_se, rdqs_se, rdqs_off, strobe_pol};
    endfunction

    // Present one request for a single edge; returns at the negedge after it.
    task automatic send(input logic [4:0] m, input logic [13:0] rt);
        @(negedge clk);
        {r_ck, r_wck, r_rse, r_off, r_pol} = m;
        rate = rt;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [4:0] exp_mode;
        exp_mode = 5'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cur_out() == 5'b0, "R1", "mode", 16'(cur_out()), 16'h0);
        check(term_en == 6'h3F, "R1", "term", 16'(term_en), 16'h3F);
        check(!busy && !req_err && !int_strobe_en, "R1", "flags",
              16'({busy, req_err, int_strobe_en}), 16'h0);

        // Table walk: R2 R3 R4 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            logic [4:0] m;
            logic       lg;
            m  = VEC[i][19:15];
            lg = VEC[i][0];
            send(m, VEC[i][14:1]);
            check(req_err == !lg, "R2 R3 R4", $sformatf("err vec%0d", i),
                  16'(req_err), 16'(!lg));
            wait_idle();
            if (lg) exp_mode = {m[4:1], m[3] & m[0]};
            check(cur_out() == exp_mode, "R2 R4 R10", $sformatf("mode vec%0d", i),
                  16'(cur_out()), 16'(exp_mode));
            check(term_en == ((exp_mode[4:1] == 4'b0) ? 6'h3F : 6'h00), "R8",
                  $sformatf("term vec%0d", i), 16'(term_en),
                  16'((exp_mode[4:1] == 4'b0) ? 6'h3F : 6'h00));
            check(int_strobe_en == exp_mode[1], "R9", $sformatf("strobe vec%0d", i),
                  16'(int_strobe_en), 16'(exp_mode[1]));
        end

        // R5 leaving full differential with S=3
        settle = 8'd3;
        send(5'b11010, 14'd1600);
        check(term_en == 6'h0 && !ck_se && busy, "R5", "term off first",
              16'({term_en, ck_se, busy}), 16'h1);
        cycles(3);
        check(!ck_se, "R5", "mode held during settle", 16'(ck_se), 16'h0);
        cycles(1);
        check(cur_out() == 5'b11010 && int_strobe_en, "R5", "mode applied",
              16'(cur_out()), 16'h1A);
        cycles(3);
        check(busy, "R5", "busy before end", 16'(busy), 16'h1);
        cycles(1);
        check(!busy, "R5", "busy released", 16'(busy), 16'h0);

        // R7 change between non-differential shapes
        send(5'b11101, 14'd1000);
        check(cur_out() == 5'b11101 && term_en == 6'h0, "R7", "mode applied at once",
              16'(cur_out()), 16'h1D);
        cycles(3);
        check(busy, "R7", "busy in settle", 16'(busy), 16'h1);
        cycles(1);
        check(!busy, "R7", "busy released", 16'(busy), 16'h0);

        // R6 returning to full differential
        send(5'b00000, 14'd6400);
        check(cur_out() == 5'b0 && term_en == 6'h0, "R6", "mode first, term off",
              16'({cur_out(), term_en}), 16'h0);
        cycles(3);
        check(term_en == 6'h0, "R6", "term still off", 16'(term_en), 16'h0);
        cycles(1);
        check(term_en == 6'h3F && busy, "R6", "term on", 16'(term_en), 16'h3F);
        cycles(4);
        check(!busy, "R6", "busy released", 16'(busy), 16'h0);

        // R11 legal request in mid-sequence is ignored
        send(5'b10000, 14'd1600);
        send(5'b11100, 14'd1600);
        check(!req_err, "R11", "no err mid-seq", 16'(req_err), 16'h0);
        wait_idle();
        check(cur_out() == 5'b10000, "R11", "first request wins",
              16'(cur_out()), 16'h10);

        // R11 illegal request on the edge where the sequence ends
        settle = 8'd2;
        send(5'b00000, 14'd6400);   // returning: ends 2*(S+1) edges after accept
        cycles(4);                  // negedge before the final edge
        check(busy, "R11", "still busy before final edge", 16'(busy), 16'h1);
        send(5'b01000, 14'd800);    // illegal, presented on the final edge
        check(!req_err && !busy, "R11", "overlap ignored",
              16'({req_err, busy}), 16'h0);
        check(cur_out() == 5'b0 && term_en == 6'h3F, "R11", "mode after overlap",
              16'({cur_out(), term_en}), 16'h3F);

        // R3 boundary with rate just above limit while idle
        send(5'b10000, 14'd1601);
        check(req_err, "R3", "1601 rejected", 16'(req_err), 16'h1);
        @(negedge clk);
        check(!req_err, "R4", "err one cycle", 16'(req_err), 16'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule